// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire serial link to a multi-channel delta-sigma converter. It lowers chip select and then watches the converter's data line. That line carries the converter's busy level, and the block does not start the serial clock until the level reads low. It then runs one 19-clock frame. During the frame it collects the status bits and the 16-bit conversion result, and it shifts an 8-bit channel-update word out on the data-in line.

At the end of the frame it decodes the sign and MSB pair into range flags. It then offers the result on a valid/ready output, tagged with the channel that produced it. Before each frame a configuration input chooses the next channel, the single-ended or differential mode, and whether the channel should change at all. If the converter stays busy for too long, the block pulses a timeout, raises chip select, waits a short gap and tries again.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, data-in is low and no result is valid.
- R2: After chip select falls, no serial clock edge occurs until the data line has been sampled low. Chip select stays low while the block waits.
- R3: The serial clock idles low while chip select is high. It has a period of 2*HALF_DIV system clocks. Each frame contains exactly 19 rising edges.
- R4: With cfg_update=1 the word sent MSB first is 1,0,1 followed by cfg_chan[4:0], where bit 4 is 1 for single-ended and 0 for differential. With cfg_update=0 the word is 1,0,0,0,0,0,0,0. Each bit is set up before a rising edge and changes only on a falling edge.
- R5: Bits are captured on rising edges. The first is the busy indicator, the second is a dummy, the third is the sign (res_pos) and the last sixteen form res_data, MSB first.
- R6: res_over is 1 exactly when the sign and MSB bits are both 1. res_under is 1 exactly when both are 0.
- R7: res_chan gives the channel in effect for that conversion. This is 00000 for the first conversion. After a frame that sent an update, the next conversion uses the address that was sent. Otherwise the address is unchanged.
- R8: A result holds valid with a stable payload until res_ready is high. No new frame begins (chip select stays high) while a result is pending.
- R9: If the data line has not read low TIMEOUT_CYC cycles after chip select fell, conv_timeout pulses for one cycle. Chip select rises in the same cycle, and a retry begins after GAP_CYC cycles.
- R10: Apart from a timeout, chip select rises only after the falling edge that follows the 19th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan | input | 5 | Next channel: bit 4 is single-ended select, bits 3:0 the channel |
| cfg_update | input | 1 | 1 to send a channel update, 0 to keep the channel |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sck | output | 1 | Serial clock, idles low |
| adc_sdi | output | 1 | Serial data toward the converter |
| adc_sdo | input | 1 | Serial data from the converter; carries the busy level before clocking |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 16 | Conversion result bits, MSB first as received |
| res_pos | output | 1 | Sign indicator: 1 for a positive input |
| res_over | output | 1 | Input above positive full scale |
| res_under | output | 1 | Input below negative full scale |
| res_chan | output | 5 | Channel that produced this result |
| conv_timeout | output | 1 | One-cycle pulse when the busy wait expires |

## Verification
A wrong bit counter or clock phase shows up at once as a frame with other than 19 rising edges, a wrong period, or a result that is off by one bit position. A wrong channel register shows up only one frame later, as a result tag that does not match the word sent on the previous frame. A broken wait shows up as a clock edge while the converter model is still busy. A broken timeout shows up as a missing pulse, or as chip select left low, during the long conversion.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int FRAME_BITS = 19;
    localparam int WORD_BITS  = 8;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 16;
    localparam int BCW        = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_FIN,
        ST_GAP
    } afr_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 pos;
        logic                 over;
        logic                 under;
    } afr_result_t;

    // Control prefix 101 moves the channel; 100 keeps it and the address is don't-care.
    function automatic logic [WORD_BITS-1:0] afr_make_word(
        input logic                 upd,
        input logic [ADDR_BITS-1:0] addr
    );
        if (upd) return {3'b101, addr};
        return {3'b100, {ADDR_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/afr_sck_gen.sv
module afr_sck_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } gen_t;

    gen_t gen_q, gen_d;

    always_comb begin
        gen_d    = gen_q;
        rise_now = 1'b0;
        fall_now = 1'b0;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.sck = 1'b0;
        end else if (gen_q.cnt == CW'(HALF_DIV - 1)) begin
            gen_d.cnt = '0;
            gen_d.sck = ~gen_q.sck;
            rise_now  = ~gen_q.sck;
            fall_now  = gen_q.sck;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck = gen_q.sck;

    // R3: clock parks low once the frame engine stops running it
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);

    // R3: every edge is separated by HALF_DIV cycles, so an edge never follows an edge
    p_edge_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now || fall_now) |=> !(rise_now || fall_now) || (HALF_DIV == 1));

endmodule

// File: rtl/afr_word_tx.sv
module afr_word_tx #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] load_word,
    input  logic                 shift,
    output logic                 sdi
);
    typedef struct packed {
        logic [WORD_BITS-1:0] sr;
    } tx_t;

    tx_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (load)       tx_d.sr = load_word;
        else if (shift) tx_d.sr = {tx_q.sr[WORD_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sdi = tx_q.sr[WORD_BITS-1];

    // R4: the data-in bit only moves on a load or on a falling-edge shift
    p_sdi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sdi));

endmodule

// File: rtl/afr_range_decode.sv
module afr_range_decode
    import afr_pkg::*;
(
    input  logic [DATA_BITS:0] bits_in,
    output afr_result_t        res
);
    logic sign_b;
    logic msb_b;

    always_comb begin
        sign_b    = bits_in[DATA_BITS];
        msb_b     = bits_in[DATA_BITS-1];
        res.data  = bits_in[DATA_BITS-1:0];
        res.pos   = sign_b;
        res.over  = sign_b & msb_b;
        res.under = ~sign_b & ~msb_b;
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import afr_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int TIMEOUT_CYC = 100000,
    parameter int GAP_CYC     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  cfg_chan,
    input  logic        cfg_update,
    output logic        adc_cs_n,
    output logic        adc_sck,
    output logic        adc_sdi,
    input  logic        adc_sdo,
    output logic        res_valid,
    input  logic        res_ready,
    output logic [15:0] res_data,
    output logic        res_pos,
    output logic        res_over,
    output logic        res_under,
    output logic [4:0]  res_chan,
    output logic        conv_timeout
);
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    typedef struct packed {
        afr_state_e           state;
        logic                 cs_n;
        logic                 sdo;
        logic [DATA_BITS:0]   rx;
        logic [BCW-1:0]       bit_cnt;
        logic [TW-1:0]        wait_cnt;
        logic [GW-1:0]        gap_cnt;
        logic                 upd;
        logic [ADDR_BITS-1:0] chan;
        logic [ADDR_BITS-1:0] active_chan;
        logic                 valid;
        afr_result_t          res;
        logic [ADDR_BITS-1:0] res_chan;
        logic                 timeout;
    } ctl_t;

    ctl_t q, d;

    logic        run;
    logic        sck_rise;
    logic        sck_fall;
    logic        sck_w;
    logic        tx_load;
    logic        tx_shift;
    logic        sdi_w;
    afr_result_t decoded;

    afr_sck_gen #(.HALF_DIV(HALF_DIV)) sck_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sck      (sck_w),
        .rise_now (sck_rise),
        .fall_now (sck_fall)
    );

    afr_word_tx #(.WORD_BITS(WORD_BITS)) word_tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_word (afr_make_word(cfg_update, cfg_chan)),
        .shift     (tx_shift),
        .sdi       (sdi_w)
    );

    afr_range_decode range_i (
        .bits_in (q.rx),
        .res     (decoded)
    );

    always_comb begin
        d         = q;
        d.sdo     = adc_sdo;
        d.timeout = 1'b0;
        run       = (q.state == ST_SHIFT);
        tx_load   = 1'b0;
        tx_shift  = 1'b0;

        if (q.valid && res_ready) d.valid = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (!q.valid) begin
                    d.cs_n     = 1'b0;
                    d.wait_cnt = '0;
                    d.upd      = cfg_update;
                    d.chan     = cfg_chan;
                    tx_load    = 1'b1;
                    d.state    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                // the first cycle still holds a sample taken before chip select fell
                if (q.wait_cnt != '0 && !q.sdo) begin
                    d.bit_cnt = '0;
                    d.state   = ST_SHIFT;
                end else if (q.wait_cnt == TW'(TIMEOUT_CYC - 1)) begin
                    d.timeout = 1'b1;
                    d.cs_n    = 1'b1;
                    d.gap_cnt = '0;
                    d.state   = ST_GAP;
                end else begin
                    d.wait_cnt = q.wait_cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sck_rise) begin
                    d.rx      = {q.rx[DATA_BITS-1:0], q.sdo};
                    d.bit_cnt = q.bit_cnt + 1'b1;
                end
                if (sck_fall) begin
                    tx_shift = 1'b1;
                    if (q.bit_cnt == BCW'(FRAME_BITS)) d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                d.cs_n     = 1'b1;
                d.valid    = 1'b1;
                d.res      = decoded;
                d.res_chan = q.active_chan;
                if (q.upd) d.active_chan = q.chan;
                d.state    = ST_IDLE;
            end
            ST_GAP: begin
                if (q.gap_cnt == GW'(GAP_CYC - 1)) d.state = ST_IDLE;
                else                               d.gap_cnt = q.gap_cnt + 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.sdo   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_cs_n     = q.cs_n;
    assign adc_sck      = sck_w;
    assign adc_sdi      = sdi_w & ~q.cs_n;
    assign res_valid    = q.valid;
    assign res_data     = q.res.data;
    assign res_pos      = q.res.pos;
    assign res_over     = q.res.over;
    assign res_under    = q.res.under;
    assign res_chan     = q.res_chan;
    assign conv_timeout = q.timeout;

    // R3: no clocking while deselected
    p_sck_low_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sck);

    // R2: shifting starts only after the data line was seen low
    p_shift_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT && $past(q.state) == ST_WAIT) |-> !$past(q.sdo));

    // R3: rising-edge count never passes the frame length
    p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.bit_cnt <= BCW'(FRAME_BITS));

    // R8: held result does not move until taken
    p_hold_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(q.res) && $stable(res_chan)));

    // R8: pending result keeps the converter deselected
    p_pending_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> adc_cs_n);

    // R6: range flags never both set
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_over && res_under));

    // R9: timeout pulse coincides with release and lasts one cycle
    p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_timeout |-> (adc_cs_n && !res_valid));
    p_timeout_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_timeout |=> !conv_timeout);

    // R10: outside a timeout, release only after a full frame
    p_release_full_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_cs_n) && !conv_timeout) |-> (q.bit_cnt == BCW'(FRAME_BITS)));

endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;

    localparam int HALF = 3;
    localparam int TMO  = 300;
    localparam int GAP  = 8;
    localparam int NF   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_chan = '0;
    logic        cfg_update = 1'b0;
    logic        adc_cs_n, adc_sck, adc_sdi;
    logic        adc_sdo = 1'b1;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [15:0] res_data;
    logic        res_pos, res_over, res_under;
    logic [4:0]  res_chan;
    logic        conv_timeout;

    always #5 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(HALF), .TIMEOUT_CYC(TMO), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_update(cfg_update),
        .adc_cs_n(adc_cs_n), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_pos(res_pos), .res_over(res_over), .res_under(res_under),
        .res_chan(res_chan), .conv_timeout(conv_timeout)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] data;
        logic        pos;
        logic        over;
        logic        under;
        logic [4:0]  chan;
        logic [7:0]  word;
    } exp_t;

    exp_t        sb[$];
    logic [16:0] codes[NF];
    int          clen[NF];
    logic        cupd[NF];
    logic [4:0]  cch[NF];

    // converter model state
    int          conv_left = 0;
    int          conv_n = 0;
    logic [18:0] frame = '0;
    int          rises = 0;
    int          falls = 0;
    int          since_rise = 0;
    logic [7:0]  word = '0;
    logic        sck_p = 1'b0;
    logic        cs_p = 1'b1;
    logic [7:0]  words_q[$];
    int          rise_q[$];
    int          m_err_busy = 0;
    int          m_err_cs = 0;
    int          m_err_period = 0;
    int          tmo_cnt = 0;

    initial begin
        codes[0] = {1'b1, 16'h1234}; clen[0] = 60;  cupd[0] = 1'b1; cch[0] = 5'h13;
        codes[1] = {1'b1, 16'hC000}; clen[1] = 60;  cupd[1] = 1'b0; cch[1] = 5'h1F;
        codes[2] = {1'b0, 16'h7FFF}; clen[2] = 60;  cupd[2] = 1'b1; cch[2] = 5'h05;
        codes[3] = {1'b0, 16'hF000}; clen[3] = 60;  cupd[3] = 1'b0; cch[3] = 5'h00;
        codes[4] = {1'b1, 16'h0000}; clen[4] = 1200; cupd[4] = 1'b1; cch[4] = 5'h1A;
        codes[5] = {1'b0, 16'h0001}; clen[5] = 60;  cupd[5] = 1'b1; cch[5] = 5'h0F;
        codes[6] = {1'b1, 16'hFFFF}; clen[6] = 60;  cupd[6] = 1'b0; cch[6] = 5'h02;
        codes[7] = {1'b0, 16'h8000}; clen[7] = 60;  cupd[7] = 1'b1; cch[7] = 5'h11;
        conv_left = clen[0];
        frame     = {2'b00, codes[0]};
    end

    // converter model, evaluated away from the active edge
    always @(negedge clk) begin
        if (conv_left > 0) conv_left--;
        since_rise++;
        if (adc_sck && !sck_p) begin
            if (conv_left > 0) m_err_busy++;
            if (adc_cs_n) m_err_cs++;
            if (rises > 0 && since_rise != 2 * HALF) m_err_period++;
            since_rise = 0;
            rises++;
            if (rises <= 8) word = {word[6:0], adc_sdi};
        end
        if (!adc_sck && sck_p) begin
            falls++;
            if (falls == 19) begin
                words_q.push_back(word);
                rise_q.push_back(rises);
                conv_n++;
                conv_left = (conv_n < NF) ? clen[conv_n] : 60;
                frame = {2'b00, (conv_n < NF) ? codes[conv_n] : 17'h0};
                rises = 0;
                falls = 0;
            end
        end
        if (adc_cs_n && !cs_p && (falls != 0 || rises != 0)) m_err_cs++;
        if (conv_timeout) begin
            tmo_cnt++;
            chk(adc_cs_n == 1'b1, "R9", "chip select with timeout", int'(adc_cs_n), 1);
        end
        sck_p = adc_sck;
        cs_p  = adc_cs_n;
        adc_sdo = adc_cs_n ? 1'b1 : ((falls == 0) ? (conv_left > 0) : frame[18 - falls]);
    end

    task automatic drive_expected();
        logic [4:0] ch;
        ch = 5'h00;
        for (int n = 0; n < NF; n++) begin
            exp_t e;
            e.data  = codes[n][15:0];
            e.pos   = codes[n][16];
            e.over  = codes[n][16] & codes[n][15];
            e.under = ~codes[n][16] & ~codes[n][15];
            e.chan  = ch;
            e.word  = cupd[n] ? {3'b101, cch[n]} : 8'b1000_0000;
            sb.push_back(e);
            if (cupd[n]) ch = cch[n];
        end
    endtask

    task automatic monitor_run();
        int tmo_at4;
        tmo_at4 = 0;
        for (int n = 0; n < NF; n++) begin
            exp_t e;
            int   stall;
            do @(negedge clk); while (!res_valid);
            e = sb.pop_front();
            chk(res_data == e.data, "R5", "result data", int'(res_data), int'(e.data));
            chk(res_pos == e.pos, "R5", "sign bit", int'(res_pos), int'(e.pos));
            chk(res_over == e.over, "R6", "overrange", int'(res_over), int'(e.over));
            chk(res_under == e.under, "R6", "underrange", int'(res_under), int'(e.under));
            chk(res_chan == e.chan, "R7", "channel tag", int'(res_chan), int'(e.chan));
            if (words_q.size() > 0) begin
                logic [7:0] w;
                int         r;
                w = words_q.pop_front();
                r = rise_q.pop_front();
                chk(w == e.word, "R4", "update word", int'(w), int'(e.word));
                chk(r == 19, "R3", "rising edges per frame", r, 19);
            end else begin
                chk(1'b0, "R4", "no word captured", 0, 1);
            end
            if (n == 3) chk(tmo_cnt == 0, "R9", "timeouts before long conversion", tmo_cnt, 0);
            if (n == 4) begin
                chk(tmo_cnt >= 1, "R9", "timeout during long conversion", tmo_cnt, 1);
                tmo_at4 = tmo_cnt;
            end
            stall = (n == 2) ? 25 : ((n == 5) ? 4 : 0);
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                chk(adc_cs_n && res_valid && res_data == e.data && res_chan == e.chan,
                    "R8", "held result while stalled", int'(res_valid), 1);
            end
            if (n + 1 < NF) begin
                cfg_update = cupd[n + 1];
                cfg_chan   = cch[n + 1];
            end
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
            chk(!res_valid, "R8", "valid drops after accept", int'(res_valid), 0);
        end
        chk(tmo_cnt == tmo_at4, "R9", "no timeouts after long conversion", tmo_cnt, tmo_at4);
        chk(m_err_busy == 0, "R2", "clock edges while busy", m_err_busy, 0);
        chk(m_err_cs == 0, "R10", "early or deselected clocking", m_err_cs, 0);
        chk(m_err_period == 0, "R3", "clock period errors", m_err_period, 0);
        chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    endtask

    initial begin
        drive_expected();
        cfg_update = cupd[0];
        cfg_chan   = cch[0];
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "reset chip select", int'(adc_cs_n), 1);
        chk(adc_sck == 1'b0, "R1", "reset serial clock", int'(adc_sck), 0);
        chk(adc_sdi == 1'b0, "R1", "reset data-in", int'(adc_sdi), 0);
        chk(res_valid == 1'b0, "R1", "reset valid", int'(res_valid), 0);
        rst_n = 1'b1;
        fork
            monitor_run();
            begin
                repeat (100000) @(negedge clk);
                chk(1'b0, "R8", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule